// File: doc/BRIEF.md
# Per-Pin Interrupt Condition Detector

This block watches a group of input pins (32 by default) and raises a single interrupt request for a parent interrupt controller. Each pin first passes through a synchronizer chain. The pin's own control register holds a 4-bit mode code. That code selects what the pin reacts to: nothing, a low level, a high level, a rising edge, a falling edge, or any edge. When the selected condition occurs, the pin's bit is set in a shared event register. The bit stays set until software writes a 1 to it.

Software reaches the block through a simple memory-mapped register port. A write strobe and a read strobe each act in one cycle. Read data comes back one cycle after the read strobe. The port never stalls, so it has no back-pressure. There are also three 32-bit filter-setting registers. They hold whatever is written to them and have no effect on detection.

Top module: `pin_irq_detect`

## Requirements
- R1: The control register of pin n is at byte offset 4*n. Its mode code is bits 19:16 of the written word. A read returns that code in bits 19:16 and zeros in every other bit.
- R2: Mode 0x0 disables detection. Any code other than 0x8, 0x9, 0xA, 0xB or 0xC also disables detection. Writing 0 to a control register masks the pin.
- R3: Level modes set the pin's event bit on every cycle in which the synchronized pin is at the selected level: 0x8 for low, 0xC for high. If software clears the bit while the level is still present, the bit sets again at once.
- R4: Edge modes compare the synchronized pin with its previous sample. Code 0x9 reacts to 0→1, 0xA reacts to 1→0, and 0xB reacts to either transition.
- R5: The event register is at offset 0xA0 and reads back the pin flags. Writing a 1 to a bit clears that flag. Writing a 0 to a bit leaves it unchanged. A set flag stays set until it is cleared.
- R6: If a new event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: irq_o is a register holding the OR of all event flags. It follows the flags with one cycle of latency.
- R8: The filter registers at 0xC0, 0xC4 and 0xC8 store all 32 bits written to them and read back unchanged. They have no effect on detection.
- R9: Each pin passes through SYNC_STAGES flip-flops before detection. For a rising edge in mode 0x9, the flag sets SYNC_STAGES+1 edges after the pin changes, and irq_o rises one edge after that. After reset, all flags, all modes and irq_o are 0.
- R10: A read of any unmapped offset returns 0. This includes control offsets for pins that do not exist. A write to an unmapped offset changes no register.
- R11: bus_rdata is registered. It carries the value addressed by a read strobe from the clock edge that samples the strobe onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Raw pin levels, asynchronous |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench uses the default build: 32 pins, an 8-bit offset and two synchronizer stages. With that build, every one of the 16 mode codes is swept on the lowest pin, a middle pin and the highest pin. Each case applies a rise, a fall, clears under a held level, and a zero write to the event register. Because all 32 status bits are compared, stray flags on other pins are caught as well. The two-stage chain keeps the flag and irq_o latency short enough to check cycle by cycle. It also lets the bench place a clearing write on exactly the edge where an event lands.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam logic [3:0] MODE_OFF  = 4'h0;
  localparam logic [3:0] MODE_LOW  = 4'h8;
  localparam logic [3:0] MODE_RISE = 4'h9;
  localparam logic [3:0] MODE_FALL = 4'hA;
  localparam logic [3:0] MODE_ANY  = 4'hB;
  localparam logic [3:0] MODE_HIGH = 4'hC;

  localparam int MODE_LSB  = 16;
  localparam int STAT_OFS  = 'hA0;
  localparam int FEN_OFS   = 'hC0;
  localparam int FCLK_OFS  = 'hC4;
  localparam int FWID_OFS  = 'hC8;
  localparam int NUM_FILT  = 3;

  function automatic logic mode_active(input logic [3:0] m);
    return (m == MODE_LOW) || (m == MODE_RISE) || (m == MODE_FALL) ||
           (m == MODE_ANY) || (m == MODE_HIGH);
  endfunction
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pin_irq_cell.sv
module pin_irq_cell
  import pin_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_i,
  input  logic       mode_we,
  input  logic [3:0] mode_wd,
  input  logic       clr_i,
  output logic [3:0] mode_o,
  output logic       flag_o
);
  logic [3:0] mode_q;
  logic       prev_q;
  logic       flag_q;
  logic       evt;

  always_comb begin
    case (mode_q)
      MODE_LOW:  evt = !s_i;
      MODE_RISE: evt = s_i && !prev_q;
      MODE_FALL: evt = !s_i && prev_q;
      MODE_ANY:  evt = s_i ^ prev_q;
      MODE_HIGH: evt = s_i;
      default:   evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_wd;
      prev_q <= s_i;
      // a fresh event outranks a same-cycle clear
      flag_q <= evt | (flag_q & ~clr_i);
    end
  end

  assign mode_o = mode_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_o
);
  localparam int IW = AW - 2;

  logic [NPINS-1:0]      pin_s;
  logic [NPINS-1:0]      flag_q;
  logic [NPINS-1:0]      clr_vec;
  logic [NPINS-1:0][3:0] mode_q;
  logic [NUM_FILT-1:0][31:0] filt_q;
  logic [NUM_FILT-1:0]   filt_hit;
  logic                  stat_hit;
  logic                  ctrl_hit;
  logic [IW-1:0]         idx;
  logic [31:0]           rd_val;

  assign idx      = bus_addr[AW-1:2];
  assign ctrl_hit = (bus_addr[1:0] == 2'b00) && (idx < IW'(NPINS));
  assign stat_hit = bus_addr == AW'(STAT_OFS);
  assign filt_hit[0] = bus_addr == AW'(FEN_OFS);
  assign filt_hit[1] = bus_addr == AW'(FCLK_OFS);
  assign filt_hit[2] = bus_addr == AW'(FWID_OFS);
  assign clr_vec  = (bus_wr && stat_hit) ? bus_wdata[NPINS-1:0] : '0;

  pin_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_i),
    .q_o   (pin_s)
  );

  generate
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
      pin_irq_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_i     (pin_s[g]),
        .mode_we (bus_wr && ctrl_hit && (idx == IW'(g))),
        .mode_wd (bus_wdata[MODE_LSB +: 4]),
        .clr_i   (clr_vec[g]),
        .mode_o  (mode_q[g]),
        .flag_o  (flag_q[g])
      );
    end
    for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_q[f] <= '0;
        else if (bus_wr && filt_hit[f]) filt_q[f] <= bus_wdata;
      end
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    if (ctrl_hit) begin
      for (int i = 0; i < NPINS; i++)
        if (idx == IW'(i)) rd_val[MODE_LSB +: 4] = mode_q[i];
    end else if (stat_hit) begin
      rd_val[NPINS-1:0] = flag_q;
    end else begin
      for (int f = 0; f < NUM_FILT; f++)
        if (filt_hit[f]) rd_val = filt_q[f];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_val;
      irq_o <= |flag_q;
    end
  end
endmodule

// File: rtl/pin_irq_detect_chk.sv
module pin_irq_detect_chk
  import pin_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [AW-1:0]         bus_addr,
  input logic [31:0]           bus_wdata,
  input logic [NPINS-1:0]      flag,
  input logic [NPINS-1:0][3:0] mode,
  input logic [NPINS-1:0]      pin_s,
  input logic                  irq_o
);
  a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag) |=> irq_o);
  a_r7_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !(|flag) |=> !irq_o);

  generate
    for (genvar g = 0; g < NPINS; g++) begin : g_chk
      a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_active(mode[g]) && !flag[g]) |=> !flag[g]);
      a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[g] && !(bus_wr && bus_addr == AW'(STAT_OFS) && bus_wdata[g])) |=> flag[g]);
      a_r3_level_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[g] == MODE_HIGH && pin_s[g]) |=> flag[g]);
      a_r3_level_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[g] == MODE_LOW && !pin_s[g]) |=> flag[g]);
    end
  endgenerate
endmodule

bind pin_irq_detect pin_irq_detect_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .flag      (flag_q),
  .mode      (mode_q),
  .pin_s     (pin_s),
  .irq_o     (irq_o)
);

// File: tb/pin_irq_detect_tb.sv
module pin_irq_detect_tb;
  localparam int NPINS = 32;
  localparam int AW    = 8;
  localparam int SYNC  = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pins_i = '0;
  logic             bus_wr = 1'b0;
  logic             bus_rd = 1'b0;
  logic [AW-1:0]    bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pin_irq_detect #(.NPINS(NPINS), .AW(AW), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] bitv(input int p, input logic v);
    return v ? (32'h1 << p) : 32'h0;
  endfunction

  task automatic stat_check(input string req, input logic [31:0] exp);
    logic [31:0] d;
    rd('hA0, d);
    check(req, d, exp);
    check({req, " irq R7"}, {31'h0, irq_o}, {31'h0, exp != 0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int pins_list[3];
    pins_list[0] = 0; pins_list[1] = 13; pins_list[2] = 31;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R9 reset state
    rd('hA0, d);  check("R9 reset flags", d, 32'h0);
    rd('h7C, d);  check("R9 reset mode", d, 32'h0);
    check("R9 reset irq", {31'h0, irq_o}, 32'h0);

    // R8 filter registers
    wr('hC0, 32'hDEAD_BEEF); wr('hC4, 32'h1234_5678); wr('hC8, 32'h0000_00FF);
    rd('hC0, d); check("R8 filt0", d, 32'hDEAD_BEEF);
    rd('hC4, d); check("R8 filt1", d, 32'h1234_5678);
    rd('hC8, d); check("R8 filt2", d, 32'h0000_00FF);

    // R10 unmapped offsets
    wr('hB0, 32'hFFFF_FFFF);
    rd('hB0, d); check("R10 unmapped", d, 32'h0);
    rd('h80, d); check("R10 beyond pins", d, 32'h0);
    rd('hC0, d); check("R10 filt intact", d, 32'hDEAD_BEEF);
    stat_check("R10 no flags", 32'h0);

    // R1..R5 sweep of all codes on three pins
    foreach (pins_list[k]) begin
      for (int c = 0; c < 16; c++) begin
        int p;
        logic [3:0] cc;
        p = pins_list[k];
        cc = 4'(c);
        wr(4 * p, 32'hA5A0_5A5A | ({28'h0, cc} << 16));
        rd(4 * p, d); check("R1 mode readback R11", d, {12'h0, cc, 16'h0});
        wr('hA0, 32'hFFFF_FFFF); cyc(4);
        stat_check("R3 low level idle", bitv(p, cc == 4'h8));
        wr('hA0, 32'h0);
        stat_check("R5 zero write", bitv(p, cc == 4'h8));
        pins_i[p] = 1'b1; cyc(6);
        stat_check("R4 rise", bitv(p, cc inside {4'h8, 4'h9, 4'hB, 4'hC}));
        wr('hA0, 32'hFFFF_FFFF); cyc(3);
        stat_check("R3 high persists", bitv(p, cc == 4'hC));
        pins_i[p] = 1'b0; cyc(6);
        stat_check("R4 fall", bitv(p, cc inside {4'h8, 4'hA, 4'hB, 4'hC}));
        wr('hA0, 32'hFFFF_FFFF); cyc(3);
        stat_check("R3 low persists", bitv(p, cc == 4'h8));
        wr(4 * p, 32'h0); wr('hA0, 32'hFFFF_FFFF); cyc(3);
        stat_check("R2 masked", 32'h0);
      end
    end

    // R9 latency of flag and irq
    wr(4 * 1, 32'h0009_0000);
    pins_i[1] = 1'b1;
    cyc(SYNC + 1);
    check("R9 irq not yet", {31'h0, irq_o}, 32'h0);
    cyc(1);
    check("R9 irq rises", {31'h0, irq_o}, 32'h1);
    wr('hA0, 32'h2); cyc(2);
    check("R7 irq drops", {31'h0, irq_o}, 32'h0);

    // R6 event and clear in same cycle
    wr(4 * 3, 32'h000B_0000);
    pins_i[3] = 1'b1; cyc(6);
    stat_check("R6 pre-set", 32'h8);
    pins_i[3] = 1'b0;
    cyc(SYNC);
    wr('hA0, 32'h8);
    stat_check("R6 event beats clear", 32'h8);
    wr('hA0, 32'h8); cyc(2);
    stat_check("R6 later clear", 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule